// File: doc/BRIEF.md
# Hall-Period Speed Capture Timer

This block times the rotor of a brushless motor. A free-running 16-bit counter advances once per prescaled tick of the system clock. A position-change strobe arrives each time the validated Hall state moves. After a selectable number of strobes, the block latches the running count as the period and restarts the count from zero. Downstream logic or firmware converts that period into speed. Speed in rpm is ten times the tick frequency times the strobes per capture, divided by the product of the period and the pole-pair count.

Two settings are available. One picks the tick rate, from the system clock undivided down to one tick in 1024 cycles. The other picks how many strobes make up one measurement: one (60 electrical degrees), three (180 degrees) or six (a full electrical turn). The block treats a change to either setting as the start of a new run, so a measurement built from mixed settings is never reported. It also discards the first capture after enable or after a setting change, because the start of that interval is unknown. A period that outgrows 16 bits stops at 0xFFFF and raises a sticky overflow flag.

Top module: `hall_period_capture`

## Requirements
- R1: While rst_n is low and after its release, period reads 0, cap_irq reads 0 and ovf reads 0.
- R2: div_sel sets the tick rate. Codes 0 to 5 give one tick every 1, 4, 16, 64, 256 and 1024 clock cycles, and codes 6 and 7 act as 1024. The tick phase restarts at every capture.
- R3: span_sel sets the strobes per capture. Code 0 gives 1 strobe (60 degrees), code 1 gives 3 strobes (180 degrees), and codes 2 and 3 give 6 strobes (360 degrees). A capture occurs on every such strobe counted since the previous capture.
- R4: The captured period equals the number of ticks in the clock cycles strictly between two consecutive capture strobes. A tick that falls in the capture cycle itself is not counted. period and cap_irq take the new value in the clock cycle after the capture strobe is sampled.
- R5: cap_irq is high for exactly one cycle per valid capture. period changes only together with cap_irq.
- R6: The first capture after enable rises, or after a setting change, is discarded: cap_irq stays low and period keeps its value.
- R7: A clock cycle in which div_sel or span_sel differs from its value in the previous cycle clears the counter, the strobe tally and the prescaler. A strobe sampled in that cycle is ignored.
- R8: The counter stops at 0xFFFF. A tick that arrives while the counter holds 0xFFFF sets ovf, and ovf stays set.
- R9: ovf_clr clears ovf and overrides a simultaneous set. Any capture, discarded or not, also clears ovf.
- R10: While enable is low, the block ignores strobes, holds period, and keeps the counter, tally, arming state and ovf cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run enable; low holds the measurement machinery idle |
| div_sel | input | 3 | Tick rate code |
| span_sel | input | 2 | Strobes-per-capture code |
| pos_step | input | 1 | One-cycle strobe per validated position change |
| ovf_clr | input | 1 | Clears the overflow flag |
| period | output | 16 | Last valid captured tick count |
| cap_irq | output | 1 | One-cycle pulse when period is updated |
| ovf | output | 1 | Sticky counter-saturation flag |

## Verification
The assertions check, on every cycle, the properties that do not depend on history:
- cap_irq only ever follows a sampled strobe.
- A cycle that flushes the block never produces an interrupt.
- period holds still unless cap_irq is rising with it.
- A capture always restarts the counter from zero.
- The counter stays at 0xFFFF once it reaches it.
- ovf_clr always wins over a set.

Some behaviours need the bench's scenarios, because they depend on the exact count of clock cycles between strobes:
- the period value for each tick rate and strobe span;
- the exclusion of a tick in the capture cycle;
- the discarded first capture;
- the loss of a partial measurement when the settings change mid-run.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

  localparam int PRE_W = 10;

  typedef enum logic [1:0] {
    SPAN_60  = 2'd0,
    SPAN_180 = 2'd1,
    SPAN_360 = 2'd2,
    SPAN_ALT = 2'd3
  } span_e;

  // terminal value of the prescaler for a tick-rate code (ratio minus one)
  function automatic logic [PRE_W-1:0] pre_limit(input logic [2:0] sel);
    case (sel)
      3'd0:    pre_limit = PRE_W'(0);
      3'd1:    pre_limit = PRE_W'(3);
      3'd2:    pre_limit = PRE_W'(15);
      3'd3:    pre_limit = PRE_W'(63);
      3'd4:    pre_limit = PRE_W'(255);
      default: pre_limit = PRE_W'(1023);
    endcase
  endfunction

  // strobes that make up one measurement
  function automatic logic [2:0] span_len(input logic [1:0] sel);
    case (span_e'(sel))
      SPAN_60:  span_len = 3'd1;
      SPAN_180: span_len = 3'd3;
      default:  span_len = 3'd6;
    endcase
  endfunction

endpackage

// File: rtl/hpc_prescaler.sv
module hpc_prescaler
  import hpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] limit,
  output logic             tick
);

  logic [PRE_W-1:0] div_cnt;

  assign tick = run && !restart && (div_cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                div_cnt <= '0;
    else if (restart || !run)  div_cnt <= '0;
    else if (tick)             div_cnt <= '0;
    else                       div_cnt <= div_cnt + PRE_W'(1);
  end

endmodule

// File: rtl/hpc_tally.sv
module hpc_tally (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       step,
  input  logic [2:0] span,
  output logic       cap_evt
);

  logic [2:0] seen;

  assign cap_evt = step && !flush && (seen == span - 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen <= '0;
    else if (flush)   seen <= '0;
    else if (cap_evt) seen <= '0;
    else if (step)    seen <= seen + 3'd1;
  end

  AST_TALLY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (seen == 3'd0)); // R3

endmodule

// File: rtl/hpc_period_ctr.sv
module hpc_period_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         tick,
  input  logic         cap,
  input  logic         ovf_clr,
  output logic [W-1:0] cnt,
  output logic         ovf
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic at_top;
  assign at_top = (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (flush || cap)       cnt <= '0;
    else if (tick && !at_top)    cnt <= cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ovf <= 1'b0;
    else if (flush || ovf_clr || cap)    ovf <= 1'b0;
    else if (tick && at_top)             ovf <= 1'b1;
  end

  AST_CAP_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (cnt == '0)); // R4
  AST_SAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (at_top && !cap && !flush) |=> (cnt == TOP)); // R8
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr |=> !ovf); // R9

endmodule

// File: rtl/hall_period_capture.sv
module hall_period_capture
  import hpc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [2:0]       div_sel,
  input  logic [1:0]       span_sel,
  input  logic             pos_step,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] period,
  output logic             cap_irq,
  output logic             ovf
);

  localparam int CFG_W = 5;

  logic [CFG_W-1:0] cfg_q;
  logic             cfg_chg;
  logic             flush;
  logic             tick;
  logic             cap_evt;
  logic             cap_valid;
  logic             armed;
  logic [CNT_W-1:0] run_cnt;

  assign cfg_chg   = ({div_sel, span_sel} != cfg_q);
  assign flush     = !enable || cfg_chg;
  assign cap_valid = cap_evt && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= {div_sel, span_sel};
  end

  hpc_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (enable),
    .restart (flush || cap_evt),
    .limit   (pre_limit(div_sel)),
    .tick    (tick)
  );

  hpc_tally u_tally (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .step    (pos_step),
    .span    (span_len(span_sel)),
    .cap_evt (cap_evt)
  );

  hpc_period_ctr #(.W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .tick    (tick),
    .cap     (cap_evt),
    .ovf_clr (ovf_clr),
    .cnt     (run_cnt),
    .ovf     (ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed <= 1'b0;
    else if (flush)   armed <= 1'b0;
    else if (cap_evt) armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period  <= '0;
      cap_irq <= 1'b0;
    end else begin
      cap_irq <= cap_valid;
      if (cap_valid) period <= run_cnt;
    end
  end

  AST_IRQ_FROM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cap_irq |-> $past(pos_step)); // R5
  AST_FLUSH_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !cap_irq); // R7
  AST_PERIOD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_irq |-> $stable(period)); // R5

endmodule

// File: tb/sim_hall_period_capture.sv
`timescale 1ns/1ps
module sim_hall_period_capture;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [2:0]  div_sel;
  logic [1:0]  span_sel;
  logic        pos_step;
  logic        ovf_clr;
  logic [15:0] period;
  logic        cap_irq;
  logic        ovf;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  hall_period_capture u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_sel(div_sel),
    .span_sel(span_sel), .pos_step(pos_step), .ovf_clr(ovf_clr),
    .period(period), .cap_irq(cap_irq), .ovf(ovf)
  );

  typedef struct packed {
    logic [2:0]  dv;
    logic [1:0]  sp;
    logic [15:0] gap;
    logic [15:0] expect_cnt;
  } vec_t;

  // expected = floor((strobes_per_capture*(gap+2) - 1) / ratio)
  localparam vec_t VECS [8] = '{
    '{3'd0, 2'd0, 16'd3,    16'd4},
    '{3'd1, 2'd0, 16'd10,   16'd2},
    '{3'd0, 2'd1, 16'd2,    16'd11},
    '{3'd2, 2'd2, 16'd20,   16'd8},
    '{3'd3, 2'd1, 16'd100,  16'd4},
    '{3'd0, 2'd2, 16'd0,    16'd11},
    '{3'd4, 2'd0, 16'd600,  16'd2},
    '{3'd5, 2'd0, 16'd2100, 16'd2}
  };

  function automatic int strobes(input logic [1:0] code);
    if (code == 2'd0)      return 1;
    else if (code == 2'd1) return 3;
    else                   return 6;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) pos_step = 1'b1;
    @(negedge clk) pos_step = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    rst_n = 1'b0; enable = 1'b0; div_sel = '0; span_sel = '0;
    pos_step = 1'b0; ovf_clr = 1'b0;
    idle(3);
    chk("R1 period in reset", period, 0);
    chk("R1 cap_irq in reset", cap_irq, 0);
    chk("R1 ovf in reset", ovf, 0);
    rst_n = 1'b1;
    idle(1);
    chk("R1 period after release", period, 0);
    enable = 1'b1;
    idle(1);

    // R2 R3 R4 R6: table walk, each entry arms then measures
    for (int i = 0; i < 8; i++) begin
      int m;
      div_sel  = VECS[i].dv;
      span_sel = VECS[i].sp;
      m = strobes(VECS[i].sp);
      idle(1);
      for (int k = 0; k < 2 * m; k++) begin
        if (k > 0) idle(int'(VECS[i].gap));
        pulse();
        if (k == m - 1) chk($sformatf("R6 first capture discarded v%0d", i), cap_irq, 0);
      end
      chk($sformatf("R5 irq on capture v%0d", i), cap_irq, 1);
      chk($sformatf("R2 R3 R4 period v%0d", i), period, VECS[i].expect_cnt);
    end

    // R8 R9: saturation and overflow at ratio 1, one strobe per capture
    div_sel = 3'd0; span_sel = 2'd0;
    idle(1);
    pulse();
    idle(66000);
    chk("R8 ovf after saturation", ovf, 1);
    @(negedge clk) ovf_clr = 1'b1;
    @(negedge clk) ovf_clr = 1'b0;
    chk("R9 ovf_clr wins", ovf, 0);
    idle(1);
    chk("R8 ovf sets again at top", ovf, 1);
    pulse();
    chk("R8 saturated period", period, 16'hFFFF);
    chk("R9 capture clears ovf", ovf, 0);
    chk("R5 irq after saturated capture", cap_irq, 1);
    idle(1);
    chk("R5 irq is single cycle", cap_irq, 0);

    // R10: disabled block ignores strobes and holds period
    enable = 1'b0;
    idle(1);
    pulse();
    chk("R10 no irq while disabled", cap_irq, 0);
    chk("R10 period held while disabled", period, 16'hFFFF);
    enable = 1'b1;
    idle(1);
    pulse();
    chk("R6 discard after enable", cap_irq, 0);
    idle(3);
    pulse();
    chk("R10 period after re-enable", period, 4);

    // R7: settings change mid-measurement, strobe in the change cycle ignored
    span_sel = 2'd1;
    idle(1);
    pulse(); idle(2); pulse(); idle(2); pulse();
    pulse(); idle(2); pulse();
    @(negedge clk) begin span_sel = 2'd0; pos_step = 1'b1; end
    @(negedge clk) pos_step = 1'b0;
    chk("R7 strobe in change cycle", cap_irq, 0);
    idle(3);
    pulse();
    chk("R7 next strobe only arms", cap_irq, 0);
    chk("R7 period untouched", period, 4);
    idle(5);
    pulse();
    chk("R7 fresh measurement irq", cap_irq, 1);
    chk("R7 fresh measurement period", period, 6);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule